// File: doc/BRIEF.md
# Bit Error Tester Performance Snapshot Counter

This block keeps two running tallies for a bit error rate tester: how many bits have been received, and how many of those bits were in error. Software cannot read the running tallies directly. When a performance monitoring update is requested, both tallies are copied into holding registers, and software reads those. The running tallies then start a new interval.

The update request comes from one of two places, chosen by a mode input. The first is a local control bit owned by this tester. The second is an update strobe shared across a port or the whole device. The edge detector sits after the source mux, so only a 0-to-1 transition of the selected request starts an update. A done flag reports that the copy has happened. The flag drops once the selected request returns low.

Each holding register is presented as a low half and a high half, to suit a 16-bit register read path. A synchronous device reset, a port reset and a port power-down input all clear every register in the block.

Top module: `bert_pm_snapshot`

## Requirements
- R1: With `upd_mode` = 0 the local request `upd_local` is the update source. A 0-to-1 transition on it copies both running counts into the holding registers at the next clock edge.
- R2: With `upd_mode` = 1 the external strobe `upd_ext` is the update source. While `upd_mode` is 1, toggling `upd_local` leaves the holding registers and `upd_done` unchanged.
- R3: An update happens only on a rising edge of the selected request. Holding the request high causes no further update. A new update needs the request to go low and then high again.
- R4: On an update, the holding registers take the counts gathered since the previous update or clear. Between updates the holding registers stay stable.
- R5: On an update, the running counts restart. A bit, or an error, presented in the update cycle is counted into the new interval, so the new count starts at 1 instead of 0.
- R6: The bit count increases only when `bit_vld` is 1. The error count increases only when both `bit_vld` and `bit_err` are 1. `bit_err` without `bit_vld` is ignored.
- R7: Both running counts saturate at all-ones and do not wrap.
- R8: `upd_done` is 1 from the clock edge that performs an update. It returns to 0 at the first clock edge at which the selected request is 0.
- R9: Because the edge is taken after the source mux, changing `upd_mode` while the newly selected request is already high, and the old one low, performs an update.
- R10: `rst_n` low, `port_rst` high or `port_pd` high at a clock edge clears the running counts, the holding registers, `upd_done` and the edge detector.
- R11: Each holding register of `CNT_W` bits is read as a low half holding bits [HALF_W-1:0] and a high half holding the remaining upper bits, with `HALF_W` = `CNT_W`/2 (16 and 16 at the default width of 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| port_rst | input | 1 | Synchronous port reset, active high |
| port_pd | input | 1 | Port power-down, active high, clears the block |
| bit_vld | input | 1 | One received bit is present this cycle |
| bit_err | input | 1 | The present bit is in error |
| upd_mode | input | 1 | Update source select: 0 local bit, 1 external strobe |
| upd_local | input | 1 | Local update request bit |
| upd_ext | input | 1 | External port/device update strobe |
| bit_hold_lo | output | HALF_W | Held bit count, low half |
| bit_hold_hi | output | CNT_W-HALF_W | Held bit count, high half |
| err_hold_lo | output | HALF_W | Held error count, low half |
| err_hold_hi | output | CNT_W-HALF_W | Held error count, high half |
| upd_done | output | 1 | Update performed; cleared when the selected request is low |

## Verification
The bench builds the block with `CNT_W` = 8, so each half is 4 bits wide. With that width the saturation point of 255 is reached in a few hundred cycles. The same counts also carry into the high half, so both halves hold nonzero values. At the default width of 32, neither the all-ones stop nor the high half could be reached in a short run. The source-select, edge and done behaviour does not depend on the width, so the narrow build covers it in full.

// File: rtl/bert_pm_pkg.sv
// Package: shared types and helpers for the performance snapshot block.
// Assumes: nothing beyond standard SystemVerilog.
package bert_pm_pkg;

    // Update request source selected by the mode input.
    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_EXT   = 1'b1
    } upd_src_e;

    // Index of each counter in the generated counter array.
    localparam int unsigned CNT_IDX_BITS = 0;
    localparam int unsigned CNT_IDX_ERRS = 1;
    localparam int unsigned NUM_CNT      = 2;

endpackage

// File: rtl/bert_pm_req.sv
// Module: bert_pm_req
// Selects the update request source, detects its rising edge and keeps the
// done flag. Assumes both request inputs are already synchronous to clk.
module bert_pm_req
    import bert_pm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic mode_i,
    input  logic local_i,
    input  logic ext_i,
    output logic sel_o,
    output logic edge_o,
    output logic done_o
);

    upd_src_e src;
    logic     req_q;
    logic     done_q;

    // Decode the mode bit into a source.
    always_comb begin
        src = upd_src_e'(mode_i);
    end

    // Source mux ahead of the edge detector.
    always_comb begin
        case (src)
            SRC_EXT: sel_o = ext_i;
            default: sel_o = local_i;
        endcase
    end

    // Delayed copy of the selected request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            req_q <= 1'b0;
        end else begin
            req_q <= sel_o;
        end
    end

    // A rising edge of the selected request starts one update.
    always_comb begin
        edge_o = sel_o && !req_q;
    end

    // Done flag: set by an update, dropped when the request is low.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            done_q <= 1'b0;
        end else if (edge_o) begin
            done_q <= 1'b1;
        end else if (!sel_o) begin
            done_q <= 1'b0;
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/bert_pm_counter.sv
// Module: bert_pm_counter
// Saturating event counter with a restart input. A restart reloads the
// count with the event of the same cycle (0 or 1), so no event is lost.
// Assumes restart and inc are single-cycle qualified by the caller.
module bert_pm_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic         restart_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         at_max;

    // Detect the all-ones stop point.
    always_comb begin
        at_max = (cnt_q == CNT_MAX);
    end

    // Next count: restart, saturating increment, or hold.
    always_comb begin
        if (restart_i) begin
            cnt_d = inc_i ? CNT_ONE : '0;
        end else if (inc_i && !at_max) begin
            cnt_d = cnt_q + CNT_ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    // Count register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bert_pm_hold.sv
// Module: bert_pm_hold
// Holding register loaded from a live count on an update, presented as a
// low and a high half. Assumes load_i is a single-cycle pulse.
module bert_pm_hold #(
    parameter int unsigned W    = 32,
    parameter int unsigned HALF = W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [W-1:0]      d_i,
    output logic [W-1:0]      q_o,
    output logic [HALF-1:0]   lo_o,
    output logic [W-HALF-1:0] hi_o
);

    logic [W-1:0] hold_q;

    // Capture the live count when an update fires.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            hold_q <= '0;
        end else if (load_i) begin
            hold_q <= d_i;
        end
    end

    // Split into the two register read halves.
    always_comb begin
        lo_o = hold_q[HALF-1:0];
        hi_o = hold_q[W-1:HALF];
    end

    assign q_o = hold_q;

endmodule

// File: rtl/bert_pm_snapshot.sv
// Module: bert_pm_snapshot (top)
// Counts received bits and bit errors and copies both counts into holding
// registers on a rising edge of the mode-selected update request.
// Assumes all inputs are synchronous to clk; clears are synchronous.
module bert_pm_snapshot
    import bert_pm_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    port_rst,
    input  logic                    port_pd,
    input  logic                    bit_vld,
    input  logic                    bit_err,
    input  logic                    upd_mode,
    input  logic                    upd_local,
    input  logic                    upd_ext,
    output logic [HALF_W-1:0]       bit_hold_lo,
    output logic [CNT_W-HALF_W-1:0] bit_hold_hi,
    output logic [HALF_W-1:0]       err_hold_lo,
    output logic [CNT_W-HALF_W-1:0] err_hold_hi,
    output logic                    upd_done
);

    logic                    port_clr;
    logic                    upd_sel;
    logic                    upd_edge;
    logic [NUM_CNT-1:0]      cnt_inc;
    logic [CNT_W-1:0]        live   [NUM_CNT];
    logic [CNT_W-1:0]        held   [NUM_CNT];
    logic [HALF_W-1:0]       held_lo[NUM_CNT];
    logic [CNT_W-HALF_W-1:0] held_hi[NUM_CNT];
    logic [CNT_W-1:0]        live_bits;
    logic [CNT_W-1:0]        live_errs;
    logic [CNT_W-1:0]        hold_bits;
    logic [CNT_W-1:0]        hold_errs;

    // Port-level clear: reset or power-down of this port.
    always_comb begin
        port_clr = port_rst || port_pd;
    end

    // Qualify the count events.
    always_comb begin
        cnt_inc               = '0;
        cnt_inc[CNT_IDX_BITS] = bit_vld;
        cnt_inc[CNT_IDX_ERRS] = bit_vld && bit_err;
    end

    bert_pm_req u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (port_clr),
        .mode_i  (upd_mode),
        .local_i (upd_local),
        .ext_i   (upd_ext),
        .sel_o   (upd_sel),
        .edge_o  (upd_edge),
        .done_o  (upd_done)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        bert_pm_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (port_clr),
            .inc_i     (cnt_inc[gi]),
            .restart_i (upd_edge),
            .cnt_o     (live[gi])
        );

        bert_pm_hold #(
            .W    (CNT_W),
            .HALF (HALF_W)
        ) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (port_clr),
            .load_i (upd_edge),
            .d_i    (live[gi]),
            .q_o    (held[gi]),
            .lo_o   (held_lo[gi]),
            .hi_o   (held_hi[gi])
        );
    end

    // Route counter array entries to named signals and ports.
    always_comb begin
        live_bits   = live[CNT_IDX_BITS];
        live_errs   = live[CNT_IDX_ERRS];
        hold_bits   = held[CNT_IDX_BITS];
        hold_errs   = held[CNT_IDX_ERRS];
        bit_hold_lo = held_lo[CNT_IDX_BITS];
        bit_hold_hi = held_hi[CNT_IDX_BITS];
        err_hold_lo = held_lo[CNT_IDX_ERRS];
        err_hold_hi = held_hi[CNT_IDX_ERRS];
    end

endmodule

// File: rtl/bert_pm_snapshot_chk.sv
// Module: bert_pm_snapshot_chk
// Property checker bound to bert_pm_snapshot. It observes ports and the
// live and held counts, and keeps only guards of its own.
module bert_pm_snapshot_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_rst,
    input logic             port_pd,
    input logic             bit_vld,
    input logic             bit_err,
    input logic             upd_mode,
    input logic             upd_local,
    input logic             upd_ext,
    input logic             upd_done,
    input logic             upd_edge,
    input logic [CNT_W-1:0] live_bits,
    input logic [CNT_W-1:0] live_errs,
    input logic [CNT_W-1:0] hold_bits,
    input logic [CNT_W-1:0] hold_errs
);

    logic any_clr;
    logic sel_req;
    logic armed   = 1'b0;
    logic started = 1'b0;

    // Combined clear condition and the selected request as seen at ports.
    always_comb begin
        any_clr = !rst_n || port_rst || port_pd;
        sel_req = upd_mode ? upd_ext : upd_local;
    end

    // Guards: one clock seen at all, and one clock seen since a clear.
    always_ff @(posedge clk) begin
        started <= 1'b1;
        armed   <= !any_clr;
    end

    assert_edge_only_R3: assert property (@(posedge clk) disable iff (any_clr)
        armed && upd_edge |-> sel_req && !$past(sel_req));

    assert_done_set_R8: assert property (@(posedge clk) disable iff (any_clr)
        armed && $past(upd_edge) |-> upd_done);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (any_clr)
        armed && !$past(upd_edge) && !$past(sel_req) |-> !upd_done);

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (any_clr)
        armed && !$past(upd_edge) |-> $stable(hold_bits) && $stable(hold_errs));

    assert_capture_R4: assert property (@(posedge clk) disable iff (any_clr)
        armed && $past(upd_edge) |->
            hold_bits == $past(live_bits) && hold_errs == $past(live_errs));

    assert_restart_R5: assert property (@(posedge clk) disable iff (any_clr)
        armed && $past(upd_edge) |->
            live_bits == CNT_W'($past(bit_vld)) &&
            live_errs == CNT_W'($past(bit_vld) && $past(bit_err)));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (any_clr)
        armed && !$past(upd_edge) && $past(live_bits) == {CNT_W{1'b1}} |->
            live_bits == {CNT_W{1'b1}});

    assert_err_gate_R6: assert property (@(posedge clk) disable iff (any_clr)
        armed && !$past(upd_edge) && !($past(bit_vld) && $past(bit_err)) |->
            $stable(live_errs));

    assert_clear_R10: assert property (@(posedge clk)
        started && $past(any_clr) |->
            live_bits == '0 && live_errs == '0 && hold_bits == '0 &&
            hold_errs == '0 && !upd_done);

endmodule

bind bert_pm_snapshot bert_pm_snapshot_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_rst  (port_rst),
    .port_pd   (port_pd),
    .bit_vld   (bit_vld),
    .bit_err   (bit_err),
    .upd_mode  (upd_mode),
    .upd_local (upd_local),
    .upd_ext   (upd_ext),
    .upd_done  (upd_done),
    .upd_edge  (upd_edge),
    .live_bits (live_bits),
    .live_errs (live_errs),
    .hold_bits (hold_bits),
    .hold_errs (hold_errs)
);

// File: tb/bert_pm_snapshot_test.sv
// Scoreboard bench for bert_pm_snapshot, built narrow (CNT_W = 8).
module bert_pm_snapshot_test;

    localparam int unsigned W    = 8;
    localparam int unsigned HALF = W / 2;
    localparam int          MAXV = (1 << W) - 1;

    typedef struct {
        int    bits;
        int    errs;
        int    due;
        string tag;
    } exp_item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            port_rst = 1'b0;
    logic            port_pd = 1'b0;
    logic            bit_vld = 1'b0;
    logic            bit_err = 1'b0;
    logic            upd_mode = 1'b0;
    logic            upd_local = 1'b0;
    logic            upd_ext = 1'b0;
    logic [HALF-1:0] bit_hold_lo;
    logic [W-HALF-1:0] bit_hold_hi;
    logic [HALF-1:0] err_hold_lo;
    logic [W-HALF-1:0] err_hold_hi;
    logic            upd_done;

    int        n_cmp = 0;
    int        n_bad = 0;
    int        cyc = 0;
    bit        done_run = 1'b0;
    exp_item_t exp_q[$];

    // Model state.
    int m_bits = 0, m_errs = 0, h_bits = 0, h_errs = 0;
    bit m_done = 1'b0, m_prev = 1'b0;

    bert_pm_snapshot #(.CNT_W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_rst    (port_rst),
        .port_pd     (port_pd),
        .bit_vld     (bit_vld),
        .bit_err     (bit_err),
        .upd_mode    (upd_mode),
        .upd_local   (upd_local),
        .upd_ext     (upd_ext),
        .bit_hold_lo (bit_hold_lo),
        .bit_hold_hi (bit_hold_hi),
        .err_hold_lo (err_hold_lo),
        .err_hold_hi (err_hold_hi),
        .upd_done    (upd_done)
    );

    always #4ns clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Compare the visible halves and done flag against the model.
    task automatic check_outputs(input string tag);
        check({tag, " R11 bit lo"}, int'(bit_hold_lo), h_bits % (1 << HALF));
        check({tag, " R11 bit hi"}, int'(bit_hold_hi), h_bits >> HALF);
        check({tag, " R11 err lo"}, int'(err_hold_lo), h_errs % (1 << HALF));
        check({tag, " R11 err hi"}, int'(err_hold_hi), h_errs >> HALF);
        check({tag, " R8 done"}, int'(upd_done), int'(m_done));
    endtask

    // Driver: apply one cycle of stimulus and advance the model.
    task automatic step(input bit v, input bit e, input bit m, input bit l,
                        input bit x, input string tag);
        bit sel;
        sel       = m ? x : l;
        bit_vld   = v;
        bit_err   = e;
        upd_mode  = m;
        upd_local = l;
        upd_ext   = x;
        if (sel && !m_prev) begin
            exp_q.push_back('{bits: m_bits, errs: m_errs, due: cyc + 1, tag: tag});
            h_bits = m_bits;
            h_errs = m_errs;
            m_bits = v ? 1 : 0;
            m_errs = (v && e) ? 1 : 0;
            m_done = 1'b1;
        end else begin
            if (v && m_bits < MAXV) m_bits++;
            if (v && e && m_errs < MAXV) m_errs++;
            if (!sel) m_done = 1'b0;
        end
        m_prev = sel;
        @(negedge clk);
        check_outputs(tag);
    endtask

    // Apply one of the three clears for one cycle (kind 0 rst_n, 1 port, 2 pd).
    task automatic do_clear(input int kind, input string tag);
        bit_vld = 1'b0; bit_err = 1'b0;
        upd_local = 1'b0; upd_ext = 1'b0;
        case (kind)
            0: rst_n = 1'b0;
            1: port_rst = 1'b1;
            default: port_pd = 1'b1;
        endcase
        @(negedge clk);
        rst_n = 1'b1; port_rst = 1'b0; port_pd = 1'b0;
        m_bits = 0; m_errs = 0; h_bits = 0; h_errs = 0;
        m_done = 1'b0; m_prev = 1'b0;
        check_outputs(tag);
    endtask

    // Monitor: pop each expected capture in the cycle it is due.
    always @(posedge clk) begin
        #2ns;
        if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_item_t it;
            it = exp_q.pop_front();
            check({it.tag, " R4 held bits"}, int'({bit_hold_hi, bit_hold_lo}), it.bits);
            check({it.tag, " R4 held errs"}, int'({err_hold_hi, err_hold_lo}), it.errs);
            check({it.tag, " R8 done set"}, int'(upd_done), 1);
        end
    end

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            check("scoreboard drained R4", exp_q.size(), 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R10: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outputs("reset R10");

        // R1, R6: mode 0, bits with some errors and a stray error flag.
        for (int i = 0; i < 10; i++) step(1'b1, (i % 3) == 0, 0, 0, 0, "count R6");
        step(1'b0, 1'b1, 0, 0, 0, "stray err R6");
        step(1'b0, 1'b0, 0, 1, 0, "local edge R1");
        // R3: hold request high, no second update.
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 0, 1, 0, "held high R3");
        step(1'b0, 1'b0, 0, 0, 0, "local low R8");
        step(1'b1, 1'b1, 0, 0, 0, "count R6");
        // R5: event in the update cycle starts the new interval at 1.
        step(1'b1, 1'b1, 0, 1, 0, "edge with event R5");
        step(1'b1, 1'b0, 0, 1, 0, "count R5");
        step(1'b0, 1'b0, 0, 0, 0, "local low R8");
        step(1'b0, 1'b0, 0, 1, 0, "second edge R5");
        step(1'b0, 1'b0, 0, 0, 0, "local low R3");

        // R2: mode 1, local toggles are ignored.
        step(1'b1, 1'b0, 1, 0, 0, "mode ext R2");
        step(1'b1, 1'b0, 1, 1, 0, "local ignored R2");
        step(1'b1, 1'b1, 1, 0, 0, "local ignored R2");
        step(1'b1, 1'b0, 1, 1, 0, "local ignored R2");
        step(1'b0, 1'b0, 1, 1, 1, "ext edge R2");
        step(1'b0, 1'b0, 1, 1, 1, "ext held R3");
        // R9: switch to the local source while it is high and ext is low.
        step(1'b1, 1'b0, 1, 1, 0, "ext low R8");
        step(1'b0, 1'b0, 0, 1, 0, "mode toggle R9");
        step(1'b0, 1'b0, 0, 0, 0, "local low R9");

        // R7: run both counts to all-ones.
        for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 0, 0, 0, "saturate R7");
        step(1'b0, 1'b0, 0, 1, 0, "capture full R7");
        step(1'b0, 1'b0, 0, 0, 0, "local low R7");

        // R10: each clear source empties holding registers and counts.
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 20; i++) step(1'b1, i[0], 0, 0, 0, "refill R10");
            step(1'b1, 1'b0, 0, 1, 0, "capture R10");
            do_clear(k, "clear R10");
            step(1'b0, 1'b0, 0, 1, 0, "empty capture R10");
            step(1'b0, 1'b0, 0, 0, 0, "local low R10");
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule